// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block converts a 32-bit device address into a physical address by walking a two-level translation table kept in system memory. A translate request starts a word read of the first-level descriptor, found from a configured first-level table base and the top twelve address bits. The descriptor's type field decides what happens next. A section or supersection descriptor ends the walk at once. A table descriptor starts a second word read into a second-level table, and that entry gives either a 4 KB or a 64 KB page.

Supersections and 64 KB pages are stored in memory as sixteen identical copies. The walker reads only the one copy that the address selects, so the replication costs it nothing. Empty or malformed descriptors end the walk with a fault that returns the offending device address. The walker serves one request at a time. Its memory port tolerates any number of wait cycles between issuing a read and the single-cycle completion strobe.

Top module: `io_pt_walker`

## Requirements
- R1: After reset, tr_busy, tr_rsp_valid and mem_rd_valid are all low.
- R2: A request taken while idle issues a first-level read at address {l1_base[31:14], va[31:20], 2'b00}. mem_rd_valid and mem_rd_addr hold steady until mem_rd_ack arrives, however many cycles that takes.
- R3: A first-level descriptor with bits[1:0]=10 and bit 18 clear is a 1 MB section. The response gives pa = {desc[31:20], va[19:0]}, no fault, and no second read.
- R4: A first-level descriptor with bits[1:0]=10 and bit 18 set is a 16 MB supersection. The response gives pa = {desc[31:24], va[23:0]}, no fault, and no second read.
- R5: A first-level descriptor with bits[1:0]=01 points to a second-level table aligned on 1 KB. The walker then reads the word at {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level entry with bit 1 set (codes 10 or 11) is a 4 KB page, and the response gives pa = {entry[31:12], va[11:0]}.
- R7: A second-level entry with bits[1:0]=01 is a 64 KB page, and the response gives pa = {entry[31:16], va[15:0]}.
- R8: A first-level descriptor with bits[1:0]=00 (including an all-zero word) or 11 ends the walk after one read. The response has tr_rsp_fault=1, tr_rsp_fault_addr=va and tr_rsp_pa=0.
- R9: A second-level entry with bits[1:0]=00 ends the walk with tr_rsp_fault=1, tr_rsp_fault_addr=va and tr_rsp_pa=0.
- R10: tr_busy stays high from the cycle after acceptance through the single cycle in which tr_rsp_valid is high, and drops on the following cycle. A request presented while busy is ignored: it starts no read and produces no response.
- R11: A mem_rd_ack pulse while no read is outstanding is ignored, and the walker stays idle.
- R12: A successful response has tr_rsp_fault=0 and tr_rsp_fault_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_base | input | 32 | First-level table base, bits 31:14 used |
| tr_req_valid | input | 1 | Translate request strobe |
| tr_req_addr | input | 32 | Device address to translate |
| tr_busy | output | 1 | Walk in progress |
| tr_rsp_valid | output | 1 | One-cycle response strobe |
| tr_rsp_fault | output | 1 | Response is a fault |
| tr_rsp_fault_addr | output | 32 | Faulting device address, 0 on success |
| tr_rsp_pa | output | 32 | Translated physical address, 0 on fault |
| mem_rd_valid | output | 1 | Memory word read outstanding |
| mem_rd_addr | output | 32 | Byte address of the word read |
| mem_rd_ack | input | 1 | Single-cycle read completion strobe |
| mem_rd_data | input | 32 | Read data, valid with mem_rd_ack |

## Verification
The walk state shows directly at the ports. A wrong state either drops mem_rd_valid before completion, issues a read at the wrong address in the cycle after acceptance or after the first completion, or gives a response strobe that is missing, repeated or carries wrong data one cycle after the final completion. Descriptor decoding faults show only in the response fields, in the cycle after the deciding read completes. Each descriptor code is therefore exercised with wait states of zero, some and many cycles. The read addresses are compared for every walk, so a misplaced index field shows even when the final address happens to match.

// File: rtl/io_pt_walker.sv
module io_pt_walker #(
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] l1_base,
  input  logic        tr_req_valid,
  input  logic [31:0] tr_req_addr,
  output logic        tr_busy,
  output logic        tr_rsp_valid,
  output logic        tr_rsp_fault,
  output logic [31:0] tr_rsp_fault_addr,
  output logic [31:0] tr_rsp_pa,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data
);
  localparam int L1_LO = 32 - L1_IDX_W;
  localparam int L2_LO = L1_LO - L2_IDX_W;
  localparam int BASE_LO = L1_IDX_W + 2;
  localparam int L2_BASE_LO = L2_IDX_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_RSP} walk_st_t;
  walk_st_t st;

  logic [31:0] va_q, rd_addr_q, pa_q;
  logic        flt_q;

  assign tr_busy           = (st != S_IDLE);
  assign mem_rd_valid      = (st == S_L1) || (st == S_L2);
  assign mem_rd_addr       = rd_addr_q;
  assign tr_rsp_valid      = (st == S_RSP);
  assign tr_rsp_fault      = flt_q;
  assign tr_rsp_fault_addr = flt_q ? va_q : 32'd0;
  assign tr_rsp_pa         = pa_q;

  wire [1:0] code = mem_rd_data[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      rd_addr_q <= '0;
      pa_q      <= '0;
      flt_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (tr_req_valid) begin
          va_q      <= tr_req_addr;
          rd_addr_q <= {l1_base[31:BASE_LO], tr_req_addr[31:L1_LO], 2'b00};
          pa_q      <= '0;
          flt_q     <= 1'b0;
          st        <= S_L1;
        end
        S_L1: if (mem_rd_ack) begin
          case (code)
            2'b01: begin
              rd_addr_q <= {mem_rd_data[31:L2_BASE_LO], va_q[L1_LO-1:L2_LO], 2'b00};
              st        <= S_L2;
            end
            2'b10: begin
              pa_q <= mem_rd_data[18] ? {mem_rd_data[31:24], va_q[23:0]}
                                      : {mem_rd_data[31:20], va_q[19:0]};
              st   <= S_RSP;
            end
            default: begin
              flt_q <= 1'b1;
              st    <= S_RSP;
            end
          endcase
        end
        S_L2: if (mem_rd_ack) begin
          if (code[1])      pa_q  <= {mem_rd_data[31:12], va_q[11:0]};
          else if (code[0]) pa_q  <= {mem_rd_data[31:16], va_q[15:0]};
          else              flt_q <= 1'b1;
          st <= S_RSP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module io_pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tr_req_valid,
  input logic        tr_busy,
  input logic        tr_rsp_valid,
  input logic        tr_rsp_fault,
  input logic [31:0] tr_rsp_fault_addr,
  input logic [31:0] tr_rsp_pa,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_ack
);
  a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ack |=> mem_rd_valid && $stable(mem_rd_addr));
  a_r10_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> tr_busy);
  a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid |=> !tr_rsp_valid && !tr_busy);
  a_r10_rsp_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid |-> tr_busy && !mem_rd_valid);
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_busy && tr_req_valid |=> tr_busy && mem_rd_valid);
  a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tr_busy) |-> $past(tr_rsp_valid));
  a_r8_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid && tr_rsp_fault |-> tr_rsp_pa == 32'd0);
  a_r12_ok_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid && !tr_rsp_fault |-> tr_rsp_fault_addr == 32'd0);
  a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_busy && !tr_req_valid && mem_rd_ack |=> !tr_busy);
endmodule

bind io_pt_walker io_pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tr_req_valid(tr_req_valid), .tr_busy(tr_busy),
  .tr_rsp_valid(tr_rsp_valid), .tr_rsp_fault(tr_rsp_fault),
  .tr_rsp_fault_addr(tr_rsp_fault_addr), .tr_rsp_pa(tr_rsp_pa),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack)
);

// File: tb/tb_io_pt_walker.sv
module tb_io_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] l1_base = 32'h0001_0000;
  logic        tr_req_valid = 1'b0;
  logic [31:0] tr_req_addr = '0;
  logic        tr_busy, tr_rsp_valid, tr_rsp_fault, mem_rd_valid;
  logic [31:0] tr_rsp_fault_addr, tr_rsp_pa, mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int n_cmp = 0, n_bad = 0;
  int wait_cycles = 0, wcnt = 0;
  bit stray = 1'b0, done = 1'b0;
  int n_reads = 0;
  logic [31:0] rd_log [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  io_pt_walker dut (.*);

  logic [31:0] t_addr [7] = '{32'h0001_048C, 32'h0001_0D14, 32'h0001_0028,
                              32'h0002_06F0, 32'h0002_06F4, 32'h0002_071C, 32'h0001_1C00};
  logic [31:0] t_data [7] = '{32'h8AB0_0002, 32'h9C04_0002, 32'h0002_0401,
                              32'h7654_3002, 32'h1111_1003, 32'hABCD_0001, 32'h1234_5673};

  function automatic logic [31:0] lookup(logic [31:0] a);
    for (int i = 0; i < 7; i++) if (t_addr[i] == a) return t_data[i];
    return 32'd0;
  endfunction

  initial forever begin
    @(negedge clk);
    mem_rd_ack = 1'b0;
    if (mem_rd_valid) begin
      if (wcnt < wait_cycles) wcnt++;
      else begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = lookup(mem_rd_addr);
        if (n_reads < 2) rd_log[n_reads] = mem_rd_addr;
        n_reads++;
        wcnt = 0;
      end
    end else if (stray) begin
      mem_rd_ack  = 1'b1;
      mem_rd_data = 32'h8000_0002;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic walk(string tag, logic [31:0] va, int wt, logic exp_f,
                      logic [31:0] exp_pa, int exp_n, logic [31:0] a0, logic [31:0] a1,
                      bit poke_busy);
    int guard = 0;
    wait_cycles = wt; wcnt = 0; n_reads = 0;
    @(negedge clk);
    tr_req_valid = 1'b1; tr_req_addr = va;
    @(negedge clk);
    tr_req_addr = va ^ 32'h5550_0000;
    tr_req_valid = poke_busy;
    while (!tr_rsp_valid && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    tr_req_valid = 1'b0;
    check({tag, " rsp_valid"}, 32'(tr_rsp_valid), 32'd1);
    check({tag, " busy at rsp R10"}, 32'(tr_busy), 32'd1);
    check({tag, " fault"}, 32'(tr_rsp_fault), 32'(exp_f));
    check({tag, " pa"}, tr_rsp_pa, exp_pa);
    check({tag, " fault_addr R12"}, tr_rsp_fault_addr, exp_f ? va : 32'd0);
    check({tag, " read count"}, n_reads, exp_n);
    check({tag, " first read R2"}, rd_log[0], a0);
    if (exp_n > 1) check({tag, " second read R5"}, rd_log[1], a1);
    @(negedge clk);
    check({tag, " rsp ends R10"}, {30'd0, tr_rsp_valid, tr_busy}, 32'd0);
    repeat (3) @(negedge clk);
    check({tag, " no extra read R10"}, n_reads, exp_n);
  endtask

  task automatic reset_test();
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {29'd0, tr_busy, tr_rsp_valid, mem_rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic stray_ack_test();
    stray = 1'b1;
    repeat (4) @(negedge clk);
    stray = 1'b0;
    check("R11 stray ack busy", {30'd0, tr_busy, tr_rsp_valid}, 32'd0);
    check("R11 stray ack no read", 32'(mem_rd_valid), 32'd0);
  endtask

  initial begin
    reset_test();
    walk("R3 section", 32'h1234_5678, 0, 0, 32'h8AB4_5678, 1, 32'h0001_048C, 0, 0);
    walk("R4 supersection", 32'h3456_789A, 3, 0, 32'h9C56_789A, 1, 32'h0001_0D14, 0, 0);
    walk("R6 small code10", 32'h00AB_C123, 0, 0, 32'h7654_3123, 2, 32'h0001_0028, 32'h0002_06F0, 0);
    walk("R6 small code11", 32'h00AB_D456, 7, 0, 32'h1111_1456, 2, 32'h0001_0028, 32'h0002_06F4, 0);
    walk("R7 large", 32'h00AC_789A, 2, 0, 32'hABCD_789A, 2, 32'h0001_0028, 32'h0002_071C, 0);
    walk("R8 zero desc", 32'hFFF0_0000, 1, 1, 32'd0, 1, 32'h0001_3FFC, 0, 0);
    walk("R8 code11 desc", 32'h7000_0010, 0, 1, 32'd0, 1, 32'h0001_1C00, 0, 0);
    walk("R9 empty l2", 32'h00AD_0000, 4, 1, 32'd0, 2, 32'h0001_0028, 32'h0002_0740, 0);
    walk("R10 req while busy", 32'h1234_5678, 5, 0, 32'h8AB4_5678, 1, 32'h0001_048C, 0, 1);
    stray_ack_test();
    walk("R11 after stray", 32'h3456_789A, 0, 0, 32'h9C56_789A, 1, 32'h0001_0D14, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule